// File: doc/BRIEF.md
# Directory-Protocol Line Coherence Controller

This block is the coherence engine for one line of a private first-level cache in a directory-based protocol with Modified, Owned, Shared and Invalid stable states. It accepts processor requests (load, fetch, store, replacement, each optionally marked as a prefetch), messages forwarded by the directory (read and write requests from other nodes, invalidations, writeback acknowledgements) and responses (data with an acknowledgement count, or single acknowledgements). In return it issues read-miss, write-miss and writeback requests and answers forwarded traffic with data or acknowledgements.

While its own write miss is outstanding, forwarded read and write requests are noted instead of answered. Once the miss has collected its data and every acknowledgement, the noted requesters are served in turn. A small transaction record holds the acknowledgement balance, the sharer set, the pending writer and its count, the prefetch flag and a copy of the data being written back. The block also drives the line's access permission for the tag array. Every port uses a valid/ready handshake. A message is consumed only in the cycle its outgoing message, if any, is accepted.

Top module: `mosi_line_ctrl`

## Requirements
- R1: After reset the permission is invalid (0), no request, response or completion is valid and the error flag is clear.
- R2: A load (cpuOp 0) or fetch (cpuOp 1) in invalid issues a read request (reqKind 0) and makes the line busy. Data with a zero count then completes the load with that data and leaves the line read-only. A load or fetch hit in S, O or M completes at once with no request.
- R3: A store (cpuOp 2) in I or S issues a write request (reqKind 1). The miss completes when the data count plus the acknowledgements (each reduces the balance by one, and they may come before the data) reaches zero. Completion pulses doneValid with doneIsStore one cycle after the last message and leaves the line read-write.
- R4: A processor request is never accepted while the line is in a transient state (busy, or writeback in flight). No more than one message of any port is consumed per cycle.
- R5: In M a forwarded read (fwdKind 0) sends line data to the one-hot destination of fwdSrc with the request's count and leaves the line read-only (O). A forwarded write (fwdKind 1) in M or O sends data and leaves it invalid.
- R6: A replacement (cpuOp 3) in M or O issues a writeback (reqKind 2) carrying the line data and makes the line invalid. Forwarded reads or writes are then answered from the saved copy, and the writeback ack (fwdKind 3) returns the line to the idle state. Replacement in S drops the line silently; in I it is consumed with no effect.
- R7: An invalidation (fwdKind 2) is answered with an acknowledgement (outIsData 0) in I, S, a read miss and a write miss. S becomes invalid. After an invalidation during a read miss, the arriving data still completes the load once and the line ends invalid. During a write miss the state is kept.
- R8: Forwarded reads during a write miss are collected into a sharer set, and a forwarded write records its requester and count. On completion the sharers get data with count 0 and the line stays O. A recorded writer gets data with its count and the line ends invalid. With both, the sharers are served one message before the writer.
- R9: A store in O issues a write request and makes the line busy. Forwarded reads there are answered from the line. A forwarded write there is answered and the miss continues as an ordinary write miss.
- R10: A miss started by a prefetch completes with no doneValid pulse. A load prefetch in S, O or M, or a store prefetch in M, is consumed with no request and no completion.
- R11: A forwarded message of an unknown kind (fwdKind 4 to 7) is consumed without changing the line and sets errFlag, which stays set until reset.
- R12: The permission encoding is 0 invalid, 1 read-only, 2 read-write, 3 busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Processor request consumed |
| cpuOp | input | 2 | 0 load, 1 fetch, 2 store, 3 replacement |
| cpuPrefetch | input | 1 | Request is a prefetch |
| fwdValid | input | 1 | Forwarded message valid |
| fwdReady | output | 1 | Forwarded message consumed |
| fwdKind | input | 3 | 0 read, 1 write, 2 invalidate, 3 writeback ack, others unknown |
| fwdSrc | input | ID_W | Requester node of the forwarded message |
| fwdAcks | input | ACK_W | Acknowledgement count the requester needs |
| rspValid | input | 1 | Response valid |
| rspReady | output | 1 | Response consumed |
| rspIsData | input | 1 | 1 data, 0 single acknowledgement |
| rspAcks | input | ACK_W | Acknowledgements still to come with this data |
| rspData | input | DATA_W | Response data |
| reqValid | output | 1 | Request to directory valid |
| reqReady | input | 1 | Request accepted |
| reqKind | output | 2 | 0 read miss, 1 write miss, 2 writeback |
| reqData | output | DATA_W | Writeback data |
| outValid | output | 1 | Outgoing response valid |
| outReady | input | 1 | Outgoing response accepted |
| outIsData | output | 1 | 1 data, 0 acknowledgement |
| outDest | output | NODES | One-hot or multi-hot destination set |
| outAcks | output | ACK_W | Count forwarded to the receiver |
| outData | output | DATA_W | Response data |
| doneValid | output | 1 | One-cycle processor completion |
| doneIsStore | output | 1 | Completion is for a store |
| doneData | output | DATA_W | Line data at completion |
| perm | output | 2 | Line access permission |
| errFlag | output | 1 | Sticky unknown-message flag |

## Verification
A wrong state shows up on the permission port during the cycle after the faulty transition. It also shows up at the next message that touches the line, as an accepted request that should stall, a missing or extra request, or a wrong destination set. Errors in the transaction record stay hidden until the write miss completes. At that point a bad acknowledgement balance finishes too early or too late, and a bad sharer set or writer record sends the final data to the wrong nodes or with the wrong count. The sequences therefore end each deferred case with its completion and compare each emitted message in order.

// File: rtl/mosi_line_pkg.sv
`timescale 1ns/1ps
package mosi_line_pkg;
  typedef enum logic [3:0] {
    ST_I, ST_S, ST_O, ST_M, ST_MI, ST_OI, ST_IS, ST_ISI,
    ST_IM, ST_IMI, ST_IMO, ST_IMOI, ST_OM
  } lineState_e;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_FETCH = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;
  localparam logic [1:0] OP_REPL  = 2'd3;

  localparam logic [1:0] FWD_READ  = 2'd0;
  localparam logic [1:0] FWD_WRITE = 2'd1;
  localparam logic [1:0] FWD_INV   = 2'd2;
  localparam logic [1:0] FWD_WBACK = 2'd3;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_WBACK = 2'd2;

  localparam logic [1:0] PERM_INV  = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'd2;
  localparam logic [1:0] PERM_BUSY = 2'd3;

  typedef struct packed {
    logic writeLine;
    logic copyToBuf;
    logic openTxn;
    logic addAcks;
    logic decAck;
    logic addSharer;
    logic recordGx;
    logic sharersSent;
    logic doneLoad;
    logic doneStore;
    logic setErr;
  } dpStrobe_t;
endpackage

// File: rtl/mosi_line_dp.sv
`timescale 1ns/1ps
module mosi_line_dp
  import mosi_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACK_W  = 4,
  parameter int NODES  = 4,
  localparam int ID_W  = $clog2(NODES),
  localparam int CNT_W = ACK_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic                    cpuPrefetch,
  input  logic [ID_W-1:0]         fwdSrc,
  input  logic [ACK_W-1:0]        fwdAcks,
  input  logic [ACK_W-1:0]        rspAcks,
  input  logic [DATA_W-1:0]       rspData,
  output logic [DATA_W-1:0]       lineData,
  output logic [DATA_W-1:0]       bufData,
  output logic signed [CNT_W-1:0] pendAcks,
  output logic                    txnPrefetch,
  output logic [NODES-1:0]        sharers,
  output logic [NODES-1:0]        gxDest,
  output logic [ACK_W-1:0]        gxAcks,
  output logic                    sharersDone,
  output logic                    doneValid,
  output logic                    doneIsStore,
  output logic                    errFlag
);
  logic [NODES-1:0] srcMask;
  assign srcMask = NODES'(1) << fwdSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineData    <= '0;
      bufData     <= '0;
      pendAcks    <= '0;
      txnPrefetch <= 1'b0;
      sharers     <= '0;
      gxDest      <= '0;
      gxAcks      <= '0;
      sharersDone <= 1'b0;
      doneValid   <= 1'b0;
      doneIsStore <= 1'b0;
      errFlag     <= 1'b0;
    end else begin
      if (stb.writeLine) lineData <= rspData;
      if (stb.copyToBuf) bufData <= lineData;
      if (stb.openTxn) begin
        pendAcks    <= '0;
        sharers     <= '0;
        txnPrefetch <= cpuPrefetch;
        sharersDone <= 1'b0;
      end
      if (stb.addAcks) pendAcks <= pendAcks + $signed({1'b0, rspAcks});
      if (stb.decAck)  pendAcks <= pendAcks - $signed(CNT_W'(1));
      if (stb.addSharer) sharers <= sharers | srcMask;
      if (stb.recordGx) begin
        gxDest <= srcMask;
        gxAcks <= fwdAcks;
      end
      if (stb.sharersSent) sharersDone <= 1'b1;
      if (stb.setErr) errFlag <= 1'b1;
      doneValid   <= stb.doneLoad | stb.doneStore;
      doneIsStore <= stb.doneStore;
    end
  end

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  a_r3_ack_update_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.addAcks && stb.decAck));
  a_r8_sharer_not_during_open: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.openTxn && stb.addSharer));
endmodule

// File: rtl/mosi_line_ctl.sv
`timescale 1ns/1ps
module mosi_line_ctl
  import mosi_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACK_W  = 4,
  parameter int NODES  = 4,
  localparam int ID_W  = $clog2(NODES),
  localparam int CNT_W = ACK_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuValid,
  output logic                    cpuReady,
  input  logic [1:0]              cpuOp,
  input  logic                    cpuPrefetch,
  input  logic                    fwdValid,
  output logic                    fwdReady,
  input  logic [2:0]              fwdKind,
  input  logic [ID_W-1:0]         fwdSrc,
  input  logic [ACK_W-1:0]        fwdAcks,
  input  logic                    rspValid,
  output logic                    rspReady,
  input  logic                    rspIsData,
  input  logic [ACK_W-1:0]        rspAcks,
  input  logic [DATA_W-1:0]       rspData,
  output logic                    reqValid,
  input  logic                    reqReady,
  output logic [1:0]              reqKind,
  output logic [DATA_W-1:0]       reqData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic                    outIsData,
  output logic [NODES-1:0]        outDest,
  output logic [ACK_W-1:0]        outAcks,
  output logic [DATA_W-1:0]       outData,
  output logic [1:0]              perm,
  output dpStrobe_t               stb,
  input  logic [DATA_W-1:0]       lineData,
  input  logic [DATA_W-1:0]       bufData,
  input  logic signed [CNT_W-1:0] pendAcks,
  input  logic                    txnPrefetch,
  input  logic [NODES-1:0]        sharers,
  input  logic [NODES-1:0]        gxDest,
  input  logic [ACK_W-1:0]        gxAcks,
  input  logic                    sharersDone
);
  lineState_e state, nextState;
  logic signed [CNT_W-1:0] sum;
  logic finish, toSharers, isLoad;
  logic fSend, fTake, fIsData, cSend, cTake, cOpen, cCopy, cLoadHit, cStoreHit;
  logic [DATA_W-1:0] fData;
  logic [1:0] cKind;
  lineState_e fNext, cNext;

  assign sum    = pendAcks + $signed({1'b0, rspAcks});
  assign isLoad = !cpuOp[1];

  always_comb begin
    nextState = state;  stb = '0;
    cpuReady = 1'b0;  fwdReady = 1'b0;  rspReady = 1'b0;
    reqValid = 1'b0;  reqKind = REQ_READ;  reqData = lineData;
    outValid = 1'b0;  outIsData = 1'b1;  outDest = NODES'(1) << fwdSrc;
    outAcks = fwdAcks;  outData = lineData;
    finish = 1'b0;  toSharers = 1'b0;
    fSend = 1'b0;  fTake = 1'b0;  fIsData = 1'b1;  fData = lineData;  fNext = state;
    cSend = 1'b0;  cTake = 1'b0;  cOpen = 1'b0;  cCopy = 1'b0;
    cLoadHit = 1'b0;  cStoreHit = 1'b0;  cKind = REQ_READ;  cNext = state;
    if (rspValid) begin
      finish = rspIsData ? (rspAcks == '0 || sum == '0) : (pendAcks == $signed(CNT_W'(1)));
      case (state)
        ST_IS, ST_ISI: if (rspIsData) begin
          rspReady = 1'b1;  stb.writeLine = 1'b1;  stb.doneLoad = !txnPrefetch;
          nextState = (state == ST_IS) ? ST_S : ST_I;
        end
        ST_OM: if (!rspIsData) begin
          rspReady = 1'b1;  stb.decAck = 1'b1;
        end
        ST_IM, ST_IMO, ST_IMI, ST_IMOI: begin
          if (!finish) begin
            rspReady = 1'b1;  stb.writeLine = rspIsData;
            stb.addAcks = rspIsData;  stb.decAck = !rspIsData;
          end else begin
            outData = rspIsData ? rspData : lineData;
            toSharers = (state == ST_IMO) || (state == ST_IMOI && !sharersDone);
            if (state == ST_IM) rspReady = 1'b1;
            else begin
              outValid = 1'b1;
              outDest  = toSharers ? sharers : gxDest;
              outAcks  = toSharers ? '0 : gxAcks;
              rspReady = outReady && !(state == ST_IMOI && !sharersDone);
              stb.sharersSent = outReady && state == ST_IMOI && !sharersDone;
            end
            if (rspReady) begin
              stb.writeLine = rspIsData;  stb.doneStore = !txnPrefetch;
              nextState = (state == ST_IM) ? ST_M : (state == ST_IMO) ? ST_O : ST_I;
            end
          end
        end
        default: ;
      endcase
    end else if (fwdValid) begin
      if (fwdKind[2]) begin
        fwdReady = 1'b1;  stb.setErr = 1'b1;
      end else begin
        case (fwdKind[1:0])
          FWD_READ: case (state)
            ST_M:         begin fSend = 1'b1; fNext = ST_O; end
            ST_O, ST_OM:  fSend = 1'b1;
            ST_MI, ST_OI: begin fSend = 1'b1; fData = bufData; end
            ST_IM, ST_IMO: begin fTake = 1'b1; stb.addSharer = 1'b1; fNext = ST_IMO; end
            default: ;
          endcase
          FWD_WRITE: case (state)
            ST_M, ST_O:   begin fSend = 1'b1; fNext = ST_I; end
            ST_OM:        begin fSend = 1'b1; fNext = ST_IM; end
            ST_MI, ST_OI: begin fSend = 1'b1; fData = bufData; end
            ST_IM:        begin fTake = 1'b1; stb.recordGx = 1'b1; fNext = ST_IMI; end
            ST_IMO:       begin fTake = 1'b1; stb.recordGx = 1'b1; fNext = ST_IMOI; end
            default: ;
          endcase
          FWD_INV: begin
            fIsData = 1'b0;
            case (state)
              ST_I, ST_ISI, ST_IM: fSend = 1'b1;
              ST_S:  begin fSend = 1'b1; fNext = ST_I; end
              ST_IS: begin fSend = 1'b1; fNext = ST_ISI; end
              default: ;
            endcase
          end
          default: if (state == ST_MI || state == ST_OI) begin
            fTake = 1'b1;  fNext = ST_I;
          end
        endcase
        if (fSend) begin
          outValid = 1'b1;  outIsData = fIsData;  outData = fData;
          outAcks = fIsData ? fwdAcks : '0;  fwdReady = outReady;
        end else fwdReady = fTake;
        if (fwdReady) nextState = fNext;
      end
    end else if (cpuValid) begin
      case (state)
        ST_I: if (cpuOp == OP_REPL) cTake = 1'b1;
              else begin
                cSend = 1'b1;  cOpen = 1'b1;
                cKind = isLoad ? REQ_READ : REQ_WRITE;
                cNext = isLoad ? ST_IS : ST_IM;
              end
        ST_S, ST_O: if (cpuOp == OP_REPL) begin
                if (state == ST_S) begin cTake = 1'b1; cNext = ST_I; end
                else begin cSend = 1'b1; cCopy = 1'b1; cKind = REQ_WBACK; cNext = ST_OI; end
              end else if (isLoad) begin
                cTake = 1'b1;  cLoadHit = !cpuPrefetch;
              end else begin
                cSend = 1'b1;  cOpen = 1'b1;  cKind = REQ_WRITE;
                cNext = (state == ST_S) ? ST_IM : ST_OM;
              end
        ST_M: if (cpuOp == OP_REPL) begin
                cSend = 1'b1;  cCopy = 1'b1;  cKind = REQ_WBACK;  cNext = ST_MI;
              end else begin
                cTake = 1'b1;
                cLoadHit  = isLoad && !cpuPrefetch;
                cStoreHit = !isLoad && !cpuPrefetch;
              end
        default: ;
      endcase
      if (cSend) begin
        reqValid = 1'b1;  reqKind = cKind;  cpuReady = reqReady;
      end else cpuReady = cTake;
      if (cpuReady) begin
        nextState = cNext;  stb.openTxn = cOpen;  stb.copyToBuf = cCopy;
        stb.doneLoad = cLoadHit;  stb.doneStore = cStoreHit;
      end
    end
  end

  always_comb begin
    case (state)
      ST_I, ST_MI, ST_OI: perm = PERM_INV;
      ST_S, ST_O:         perm = PERM_RO;
      ST_M:               perm = PERM_RW;
      default:            perm = PERM_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_I;
    else       state <= nextState;
  end

  a_r4_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cpuValid && cpuReady, fwdValid && fwdReady, rspValid && rspReady}) <= 1);
  a_r4_busy_stalls_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (perm == PERM_BUSY && cpuValid) |-> !cpuReady);
  a_r3_write_miss_not_writable: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == REQ_WRITE) |-> perm != PERM_RW);
  a_r6_wback_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == REQ_WBACK) |=> perm == PERM_INV);
endmodule

// File: rtl/mosi_line_ctrl.sv
`timescale 1ns/1ps
module mosi_line_ctrl
  import mosi_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACK_W  = 4,
  parameter int NODES  = 4,
  localparam int ID_W  = $clog2(NODES),
  localparam int CNT_W = ACK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  output logic              cpuReady,
  input  logic [1:0]        cpuOp,
  input  logic              cpuPrefetch,
  input  logic              fwdValid,
  output logic              fwdReady,
  input  logic [2:0]        fwdKind,
  input  logic [ID_W-1:0]   fwdSrc,
  input  logic [ACK_W-1:0]  fwdAcks,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic              rspIsData,
  input  logic [ACK_W-1:0]  rspAcks,
  input  logic [DATA_W-1:0] rspData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [1:0]        reqKind,
  output logic [DATA_W-1:0] reqData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsData,
  output logic [NODES-1:0]  outDest,
  output logic [ACK_W-1:0]  outAcks,
  output logic [DATA_W-1:0] outData,
  output logic              doneValid,
  output logic              doneIsStore,
  output logic [DATA_W-1:0] doneData,
  output logic [1:0]        perm,
  output logic              errFlag
);
  dpStrobe_t               stb;
  logic [DATA_W-1:0]       lineData, bufData;
  logic signed [CNT_W-1:0] pendAcks;
  logic                    txnPrefetch, sharersDone;
  logic [NODES-1:0]        sharers, gxDest;
  logic [ACK_W-1:0]        gxAcks;

  assign doneData = lineData;

  mosi_line_ctl #(.DATA_W(DATA_W), .ACK_W(ACK_W), .NODES(NODES)) ctl (
    .clk, .rstN, .cpuValid, .cpuReady, .cpuOp, .cpuPrefetch,
    .fwdValid, .fwdReady, .fwdKind, .fwdSrc, .fwdAcks,
    .rspValid, .rspReady, .rspIsData, .rspAcks, .rspData,
    .reqValid, .reqReady, .reqKind, .reqData,
    .outValid, .outReady, .outIsData, .outDest, .outAcks, .outData,
    .perm, .stb, .lineData, .bufData, .pendAcks, .txnPrefetch,
    .sharers, .gxDest, .gxAcks, .sharersDone
  );

  mosi_line_dp #(.DATA_W(DATA_W), .ACK_W(ACK_W), .NODES(NODES)) dp (
    .clk, .rstN, .stb, .cpuPrefetch, .fwdSrc, .fwdAcks, .rspAcks, .rspData,
    .lineData, .bufData, .pendAcks, .txnPrefetch, .sharers, .gxDest, .gxAcks,
    .sharersDone, .doneValid, .doneIsStore, .errFlag
  );
endmodule

// File: tb/mosi_line_ctrl_test.sv
`timescale 1ns/1ps
module mosi_line_ctrl_test;
  localparam int DATA_W = 16, ACK_W = 4, NODES = 4, ID_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 0, cpuPrefetch = 0, fwdValid = 0, rspValid = 0, rspIsData = 0;
  logic [1:0] cpuOp = 0;
  logic [2:0] fwdKind = 0;
  logic [ID_W-1:0] fwdSrc = 0;
  logic [ACK_W-1:0] fwdAcks = 0, rspAcks = 0;
  logic [DATA_W-1:0] rspData = 0;
  logic reqReady = 1, outReady = 1;
  logic cpuReady, fwdReady, rspReady, reqValid, outValid, outIsData;
  logic doneValid, doneIsStore, errFlag;
  logic [1:0] reqKind, perm;
  logic [DATA_W-1:0] reqData, outData, doneData;
  logic [NODES-1:0] outDest;
  logic [ACK_W-1:0] outAcks;

  int checks = 0, errors = 0;
  int nMsg, stalled, reqSeen, reqKindSeen, reqDataSeen, doneSeen, doneStoreSeen, doneDataSeen;
  int msgDest[4], msgAcks[4], msgData[4], msgIsData[4];

  always #2.5 clk = ~clk;

  mosi_line_ctrl #(.DATA_W(DATA_W), .ACK_W(ACK_W), .NODES(NODES)) uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fire(input int port);
    logic taken;
    nMsg = 0; reqSeen = 0; stalled = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (outValid && outReady && nMsg < 4) begin
        msgDest[nMsg] = int'(outDest); msgAcks[nMsg] = int'(outAcks);
        msgData[nMsg] = int'(outData); msgIsData[nMsg] = int'(outIsData);
        nMsg++;
      end
      if (reqValid) begin
        reqSeen = 1; reqKindSeen = int'(reqKind); reqDataSeen = int'(reqData);
      end
      taken = (port == 0) ? cpuReady : (port == 1) ? fwdReady : rspReady;
      @(posedge clk);
      if (taken) begin stalled = 0; break; end
      @(negedge clk);
    end
    if (stalled == 0) @(negedge clk);
    cpuValid = 0; fwdValid = 0; rspValid = 0;
    doneSeen = int'(doneValid); doneStoreSeen = int'(doneIsStore); doneDataSeen = int'(doneData);
  endtask

  task automatic doCpu(input logic [1:0] op, input logic pf);
    cpuOp = op; cpuPrefetch = pf; cpuValid = 1; fire(0);
  endtask
  task automatic doFwd(input logic [2:0] kind, input int src, input int acks);
    fwdKind = kind; fwdSrc = ID_W'(src); fwdAcks = ACK_W'(acks); fwdValid = 1; fire(1);
  endtask
  task automatic doRsp(input logic isData, input int acks, input int data);
    rspIsData = isData; rspAcks = ACK_W'(acks); rspData = DATA_W'(data); rspValid = 1; fire(2);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 / R12: reset state
    chk("R1", "perm", int'(perm), 0);
    chk("R1", "reqValid", int'(reqValid), 0);
    chk("R1", "outValid", int'(outValid), 0);
    chk("R1", "doneValid", int'(doneValid), 0);
    chk("R1", "errFlag", int'(errFlag), 0);

    // R2: read miss
    doCpu(0, 0);
    chk("R2", "read request", reqSeen * 16 + reqKindSeen, 16);
    chk("R12", "busy perm", int'(perm), 3);
    doCpu(0, 0);
    chk("R4", "stall in read miss", stalled, 1);
    doRsp(1, 0, 'h1234);
    chk("R2", "load done", doneSeen * 2 + doneStoreSeen, 2);
    chk("R2", "load data", doneDataSeen, 'h1234);
    chk("R12", "read-only perm", int'(perm), 1);
    doCpu(1, 0);
    chk("R2", "fetch hit done", doneSeen, 1);
    chk("R2", "fetch hit no request", reqSeen, 0);

    // R3: write miss with acks after data
    doCpu(2, 0);
    chk("R3", "write request", reqKindSeen, 1);
    doRsp(1, 2, 'hBEEF);
    chk("R3", "no early done", doneSeen, 0);
    doRsp(0, 0, 0);
    chk("R3", "no done after 1 ack", doneSeen, 0);
    chk("R3", "still busy", int'(perm), 3);
    doRsp(0, 0, 0);
    chk("R3", "store done", doneSeen * 2 + doneStoreSeen, 3);
    chk("R3", "store data", doneDataSeen, 'hBEEF);
    chk("R3", "read-write perm", int'(perm), 2);

    // R10: prefetch hit dropped
    doCpu(0, 1);
    chk("R10", "prefetch hit consumed", stalled, 0);
    chk("R10", "prefetch hit quiet", reqSeen + doneSeen, 0);

    // R5: forwarded read in M
    doFwd(0, 2, 0);
    chk("R5", "msg count", nMsg, 1);
    chk("R5", "dest", msgDest[0], 'b0100);
    chk("R5", "data", msgData[0], 'hBEEF);
    chk("R5", "owned perm", int'(perm), 1);
    doFwd(0, 1, 0);
    chk("R5", "O serves read", msgDest[0] * 2 + int'(perm == 1), 'b0010 * 2 + 1);

    // R9: store in O, forwards in OM
    doCpu(2, 0);
    chk("R9", "write request from O", reqKindSeen, 1);
    chk("R9", "busy", int'(perm), 3);
    doFwd(0, 3, 0);
    chk("R9", "read served from line", msgDest[0] * 65536 + msgData[0], 'b1000 * 65536 + 'hBEEF);
    doFwd(1, 0, 1);
    chk("R9", "write served dest", msgDest[0], 'b0001);
    chk("R9", "write served acks", msgAcks[0], 1);
    doRsp(1, 0, 'h5555);
    chk("R9", "completes as write miss", doneSeen * 2 + doneStoreSeen, 3);
    chk("R9", "now M", int'(perm), 2);

    // R6: writeback from M
    doCpu(3, 0);
    chk("R6", "writeback kind", reqKindSeen, 2);
    chk("R6", "writeback data", reqDataSeen, 'h5555);
    chk("R6", "invalid perm", int'(perm), 0);
    doFwd(0, 1, 0);
    chk("R6", "served from copy", msgData[0], 'h5555);
    doCpu(0, 0);
    chk("R4", "stall during writeback", stalled, 1);
    doFwd(3, 0, 0);
    chk("R6", "wback ack consumed", stalled * 4 + nMsg + int'(perm), 0);
    doCpu(0, 0);
    chk("R6", "idle again: read request", reqSeen * 16 + reqKindSeen, 16);
    doRsp(1, 0, 'h0101);

    // R7: invalidations
    doFwd(2, 2, 0);
    chk("R7", "ack in S", msgIsData[0] * 16 + msgDest[0], 'b0100);
    chk("R7", "S to I", int'(perm), 0);
    doFwd(2, 1, 0);
    chk("R7", "ack in I", msgIsData[0] * 16 + msgDest[0], 'b0010);
    doCpu(3, 0);
    chk("R6", "replace in I", stalled + reqSeen + int'(perm), 0);
    doCpu(0, 0);
    doFwd(2, 3, 0);
    chk("R7", "ack in read miss", msgDest[0], 'b1000);
    chk("R7", "still busy", int'(perm), 3);
    doRsp(1, 0, 'h2222);
    chk("R7", "load done once", doneSeen * 65536 + doneDataSeen, 65536 + 'h2222);
    chk("R7", "ends invalid", int'(perm), 0);

    // R8: read and write deferred, acks before data
    doCpu(2, 0);
    doFwd(2, 2, 0);
    chk("R7", "ack in write miss", msgIsData[0] * 16 + msgDest[0] + int'(perm) * 256, 'b0100 + 3 * 256);
    doFwd(0, 1, 0);
    chk("R8", "read deferred", nMsg, 0);
    doFwd(0, 2, 0);
    doFwd(1, 3, 2);
    chk("R8", "write deferred", nMsg + stalled, 0);
    doRsp(0, 0, 0);
    chk("R3", "ack before data no done", doneSeen, 0);
    doRsp(1, 1, 'h7777);
    chk("R8", "two messages", nMsg, 2);
    chk("R8", "sharers first", msgDest[0] * 16 + msgAcks[0], 'b0110 * 16);
    chk("R8", "writer second", msgDest[1] * 16 + msgAcks[1], 'b1000 * 16 + 2);
    chk("R8", "data", msgData[1], 'h7777);
    chk("R8", "store done", doneSeen * 2 + doneStoreSeen, 3);
    chk("R8", "ends invalid", int'(perm), 0);

    doCpu(2, 0);
    doFwd(1, 1, 3);
    doRsp(1, 0, 'h3333);
    chk("R8", "writer only", nMsg * 256 + msgDest[0] * 16 + msgAcks[0], 256 + 'b0010 * 16 + 3);
    chk("R8", "writer ends I", int'(perm), 0);

    doCpu(2, 0);
    doFwd(0, 3, 0);
    doRsp(1, 0, 'h4444);
    chk("R8", "sharer only", nMsg * 256 + msgDest[0] * 16 + msgAcks[0], 256 + 'b1000 * 16);
    chk("R8", "sharer ends O", int'(perm), 1);
    chk("R8", "sharer done", doneSeen, 1);

    // R6: writeback from O
    doCpu(3, 0);
    chk("R6", "writeback from O", reqKindSeen * 65536 + reqDataSeen, 2 * 65536 + 'h4444);
    doFwd(1, 2, 1);
    chk("R6", "OI write served", msgDest[0] * 65536 + msgData[0], 'b0100 * 65536 + 'h4444);
    doFwd(3, 0, 0);

    // R10: prefetch misses
    doCpu(0, 1);
    chk("R10", "prefetch read request", reqKindSeen, 0);
    doRsp(1, 0, 'h6666);
    chk("R10", "no done on prefetch miss", doneSeen, 0);
    chk("R10", "line read-only", int'(perm), 1);

    // R11: unknown kind
    doFwd(5, 0, 0);
    chk("R11", "consumed", stalled + nMsg, 0);
    chk("R11", "err set", int'(errFlag), 1);
    chk("R11", "state kept", int'(perm), 1);
    doCpu(0, 0);
    chk("R11", "line data intact", doneDataSeen, 'h6666);
    chk("R11", "err sticky", int'(errFlag), 1);

    doCpu(2, 1);
    chk("R10", "store prefetch request", reqKindSeen, 1);
    doRsp(1, 0, 'h8888);
    chk("R10", "no done store prefetch", doneSeen, 0);
    chk("R10", "writable", int'(perm), 2);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule